// File: doc/BRIEF.md
# SDRAM Write-Burst Interruption Sequencer

This block sits between a simple request front end and the command, address, mask and data pins of a single-rank SDRAM. It turns each accepted request (write burst, read burst, bank precharge or row activate) into one command on the pins. It spaces that command so that a write burst still in flight can be cut short safely. A new write cuts the old burst at once. A read cuts it and frees the data bus before read data can return. A precharge waits out the write-recovery time and masks any beats that would still have been written. An activate waits out the row-precharge time of its bank.

Each write request carries its whole burst of data. The block drives one beat per clock starting on the write command cycle. Read data is sampled from the data-in bus after the programmed CAS latency and handed back with a valid strobe. While a precharge or activate is waiting, or a read burst is still returning, the ready output is low.

A request is accepted at the rising edge where `reqValid` and `reqReady` are both high. The clock cycle that follows that edge is called the acceptance cycle `a` below. All pin outputs are registered.

Top module: `sdramWrIntrSeq`

## Requirements
- R1: After reset the pins show NOP, `dqOe` and `dqm` are low, `rdValid` is low and `reqReady` is high.
- R2: Command pins {csN,rasN,casN,weN} are 0111 (NOP) on every cycle that issues no command. The other codes are ACTIVATE 0011, READ 0101, WRITE 0100 and PRECHARGE 0010.
- R3: A WRITE request (`reqOp`=0) puts WRITE on the pins in cycle a, with the column zero-extended on `sdAddr` (bit 10 low) and the bank on `sdBank`. Beat i, taken from `reqWrData[i*DW +: DW]`, is driven in cycle a+i with `dqOe` high, for i = 0..BL-1 unless cut short. `dqOe` is low on every cycle that drives no beat.
- R4: A WRITE accepted one clock after a previous WRITE cuts the old burst. The old burst's last beat is in cycle a-1, and the new burst's beat 0 appears in the new command cycle a.
- R5: A READ request (`reqOp`=1) puts READ in cycle a, one cycle after the last kept write beat. `dqOe` is low from cycle a onward, and no further beat of the cut burst is driven.
- R6: After a READ in cycle r, `rdValid` is high in cycles r+CL+1 through r+CL+BL. In cycle r+CL+1+k, `rdData` holds the `dqIn` value of cycle r+CL+k.
- R7: A PRECHARGE request (`reqOp`=2) is issued in cycle max(a, L+TWR), where L is the cycle of the last driven write beat. `sdAddr[10]` equals `reqAllBanks`, and `sdBank` equals the requested bank.
- R8: If the cut write burst still had beats left when a PRECHARGE request was accepted, `dqm` is high from cycle a through the PRECHARGE cycle inclusive. Otherwise `dqm` stays low. `dqm` is low at all other times.
- R9: An ACTIVATE request (`reqOp`=3) is issued in cycle max(a, P+TRP), where P is the last PRECHARGE cycle that covered that bank. The row is driven on `sdAddr`.
- R10: `reqReady` is low from the acceptance cycle until the cycle before a delayed PRECHARGE or ACTIVATE issues, and from a READ's cycle r through r+CL+BL-1. It is high otherwise. Any accepted request ends a write burst in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this edge |
| reqOp | input | 2 | 0 write, 1 read, 2 precharge, 3 activate |
| reqBank | input | BW | Target bank |
| reqAllBanks | input | 1 | Precharge covers every bank |
| reqRow | input | ROW_W | Row for activate |
| reqCol | input | COL_W | Column for read or write |
| reqWrData | input | BL*DW | Write burst, beat i at bits i*DW |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| sdBank | output | BW | Bank address |
| sdAddr | output | ROW_W | Address bus |
| dqm | output | 1 | Data mask |
| dqOut | output | DW | Write data to the DQ bus |
| dqOe | output | 1 | DQ output enable |
| dqIn | input | DW | Data from the DQ bus |
| rdData | output | DW | Captured read data |
| rdValid | output | 1 | Read data strobe |

## Verification
Directed sequences isolate each interruption. They cover a full uncut burst, a write cut by a write on the next clock, a write cut by a read, and a precharge arriving mid-burst, where the mask must rise and the recovery wait is longest. They also cover a precharge long after a finished burst, where the mask must stay low and there is no wait, and an activate right after a precharge-all, which waits out the row-precharge time. A seeded random stream then mixes all four operations with zero to three idle cycles between them. This reaches back-to-back interruptions at every beat position and shows whether each spacing is measured from the right reference cycle. A bench model predicts the exact command cycle, beat values, mask window, ready window and returned read data for every cycle.

// File: rtl/sdwiPkg.sv
package sdwiPkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_PRE   = 2'd2,
    OP_ACT   = 2'd3
  } reqOp_e;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_READ  = 4'b0101;
  localparam logic [3:0] CMD_WRITE = 4'b0100;
  localparam logic [3:0] CMD_PRE   = 4'b0010;

  // Control-to-datapath strobes, all valid for the coming edge.
  typedef struct packed {
    logic loadWr;   // latch a new burst, drive beat 0 next cycle
    logic advance;  // drive the following beat next cycle
    logic capture;  // sample dqIn at this edge
  } strobe_t;

endpackage

// File: rtl/sdwiCtrl.sv
module sdwiCtrl
  import sdwiPkg::*;
#(
  parameter int BL    = 4,
  parameter int CL    = 2,
  parameter int TWR   = 2,
  parameter int TRP   = 3,
  parameter int NB    = 4,
  parameter int ROW_W = 11,
  parameter int COL_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [1:0]               reqOp,
  input  logic [$clog2(NB)-1:0]    reqBank,
  input  logic                     reqAllBanks,
  input  logic [ROW_W-1:0]         reqRow,
  input  logic [COL_W-1:0]         reqCol,
  output logic [3:0]               cmd,
  output logic [$clog2(NB)-1:0]    sdBank,
  output logic [ROW_W-1:0]         sdAddr,
  output logic                     dqm,
  output logic                     dqOe,
  output strobe_t                  strobe
);

  localparam int BW  = $clog2(NB);
  localparam int BIW = (BL > 1) ? $clog2(BL) : 1;
  localparam int WGW = $clog2(TWR + 1);
  localparam int RGW = $clog2(TRP + 1);
  localparam int RCW = $clog2(CL + BL + 1);
  localparam logic [WGW-1:0] TWR_SAT = WGW'(TWR);
  localparam logic [WGW-1:0] TWR_M1  = WGW'(TWR - 1);
  localparam logic [RGW-1:0] TRP_SAT = RGW'(TRP);
  localparam logic [RGW-1:0] TRP_M1  = RGW'(TRP - 1);
  localparam logic [BIW-1:0] LAST_BEAT = BIW'(BL - 1);
  localparam logic [RCW-1:0] CAP_LO = RCW'(CL);
  localparam logic [RCW-1:0] CAP_HI = RCW'(CL + BL - 1);

  typedef enum logic [1:0] {ST_RUN, ST_PRE_WAIT, ST_ACT_WAIT, ST_RD_BUSY} state_e;

  state_e           state, stateN;
  logic [BIW-1:0]   beatIdx, beatIdxN;
  logic             dqOeN, dqmN, mask, maskN;
  logic [WGW-1:0]   wrGap;
  logic [RGW-1:0]   rpGap [NB];
  logic [RCW-1:0]   rdCnt, rdCntN;
  logic [3:0]       cmdN;
  logic [BW-1:0]    bankN, pendBank, pendBankN;
  logic [ROW_W-1:0] addrN, pendRow, pendRowN;
  logic             pendAll, pendAllN;
  logic             accept, beatRemains, preGo, actGoReq, actGoPend;
  logic [NB-1:0]    preHit;

  assign reqReady    = (state == ST_RUN);
  assign accept      = reqValid && reqReady;
  assign beatRemains = dqOe && (beatIdx != LAST_BEAT);
  assign preGo       = (wrGap >= TWR_M1);
  assign actGoReq    = (rpGap[reqBank] >= TRP_M1);
  assign actGoPend   = (rpGap[pendBank] >= TRP_M1);

  always_comb begin
    stateN    = state;
    cmdN      = CMD_NOP;
    bankN     = sdBank;
    addrN     = sdAddr;
    dqmN      = 1'b0;
    dqOeN     = 1'b0;
    beatIdxN  = beatIdx;
    maskN     = mask;
    pendBankN = pendBank;
    pendRowN  = pendRow;
    pendAllN  = pendAll;
    rdCntN    = rdCnt;
    strobe    = '0;
    strobe.capture = (state == ST_RD_BUSY) && (rdCnt >= CAP_LO) && (rdCnt <= CAP_HI);
    if (accept) begin
      pendBankN = reqBank;
      pendRowN  = reqRow;
      pendAllN  = reqAllBanks;
      unique case (reqOp_e'(reqOp))
        OP_WRITE: begin
          cmdN = CMD_WRITE; bankN = reqBank; addrN = ROW_W'(reqCol);
          strobe.loadWr = 1'b1; dqOeN = 1'b1; beatIdxN = '0;
        end
        OP_READ: begin
          cmdN = CMD_READ; bankN = reqBank; addrN = ROW_W'(reqCol);
          rdCntN = '0; stateN = ST_RD_BUSY;
        end
        OP_PRE: begin
          maskN = beatRemains;
          dqmN  = beatRemains;
          if (preGo) begin
            cmdN = CMD_PRE; bankN = reqBank;
            addrN = '0; addrN[10] = reqAllBanks;
          end else begin
            stateN = ST_PRE_WAIT;
          end
        end
        OP_ACT: begin
          if (actGoReq) begin
            cmdN = CMD_ACT; bankN = reqBank; addrN = reqRow;
          end else begin
            stateN = ST_ACT_WAIT;
          end
        end
        default: ;
      endcase
    end else begin
      unique case (state)
        ST_RUN: begin
          if (beatRemains) begin
            strobe.advance = 1'b1; dqOeN = 1'b1; beatIdxN = beatIdx + 1'b1;
          end
        end
        ST_PRE_WAIT: begin
          dqmN = mask;
          if (preGo) begin
            cmdN = CMD_PRE; bankN = pendBank;
            addrN = '0; addrN[10] = pendAll;
            stateN = ST_RUN;
          end
        end
        ST_ACT_WAIT: begin
          if (actGoPend) begin
            cmdN = CMD_ACT; bankN = pendBank; addrN = pendRow;
            stateN = ST_RUN;
          end
        end
        ST_RD_BUSY: begin
          rdCntN = rdCnt + 1'b1;
          if (rdCnt == CAP_HI) stateN = ST_RUN;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      preHit[b] = (cmdN == CMD_PRE) && (addrN[10] || (bankN == BW'(b)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN; cmd <= CMD_NOP; sdBank <= '0; sdAddr <= '0;
      dqm <= 1'b0; dqOe <= 1'b0; beatIdx <= '0; mask <= 1'b0;
      pendBank <= '0; pendRow <= '0; pendAll <= 1'b0; rdCnt <= '0;
      wrGap <= TWR_SAT;
    end else begin
      state <= stateN; cmd <= cmdN; sdBank <= bankN; sdAddr <= addrN;
      dqm <= dqmN; dqOe <= dqOeN; beatIdx <= beatIdxN; mask <= maskN;
      pendBank <= pendBankN; pendRow <= pendRowN; pendAll <= pendAllN;
      rdCnt <= rdCntN;
      if (dqOeN) wrGap <= '0;
      else if (wrGap < TWR_SAT) wrGap <= wrGap + 1'b1;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : gRpGap
    always_ff @(posedge clk) begin
      if (rst) rpGap[g] <= TRP_SAT;
      else if (preHit[g]) rpGap[g] <= '0;
      else if (rpGap[g] < TRP_SAT) rpGap[g] <= rpGap[g] + 1'b1;
    end
  end

  // R3: a write command always carries beat 0 on the bus
  p_write_beat0_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_WRITE) |-> (dqOe && beatIdx == '0));
  // R5: bus is released on the read command cycle
  p_read_release_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_READ) |-> !dqOe);
  // R7: precharge never lands inside write recovery
  p_pre_twr_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> (wrGap >= TWR_SAT));
  // R8: a masked cycle never drives data
  p_dqm_idle_bus_r8: assert property (@(posedge clk) disable iff (rst)
    dqm |-> !dqOe);
  // R9: activate respects row precharge time of its bank
  p_act_trp_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_ACT) |-> (rpGap[sdBank] >= TRP_SAT));
  // R10: no request is taken while a precharge is pending
  p_wait_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE_WAIT) |-> (!reqReady && cmd == CMD_NOP));

endmodule

// File: rtl/sdwiData.sv
module sdwiData
  import sdwiPkg::*;
#(
  parameter int DW = 16,
  parameter int BL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobe,
  input  logic [BL*DW-1:0] reqWrData,
  input  logic [DW-1:0]    dqIn,
  output logic [DW-1:0]    dqOut,
  output logic [DW-1:0]    rdData,
  output logic             rdValid
);

  localparam int BIW = (BL > 1) ? $clog2(BL) : 1;

  logic [DW-1:0]  wrBuf [BL];
  logic [BIW-1:0] nextBeat;

  for (genvar i = 0; i < BL; i++) begin : gBuf
    always_ff @(posedge clk) begin
      if (rst) wrBuf[i] <= '0;
      else if (strobe.loadWr) wrBuf[i] <= reqWrData[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dqOut <= '0; nextBeat <= '0; rdData <= '0; rdValid <= 1'b0;
    end else begin
      if (strobe.loadWr) begin
        dqOut    <= reqWrData[DW-1:0];
        nextBeat <= BIW'(1);
      end else if (strobe.advance) begin
        dqOut    <= wrBuf[nextBeat];
        nextBeat <= nextBeat + 1'b1;
      end
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= dqIn;
    end
  end

  // R3: a new burst and a continuing beat are never requested together
  p_load_xor_advance_r3: assert property (@(posedge clk) disable iff (rst)
    !(strobe.loadWr && strobe.advance));

endmodule

// File: rtl/sdramWrIntrSeq.sv
module sdramWrIntrSeq
  import sdwiPkg::*;
#(
  parameter int DW    = 16,
  parameter int BL    = 4,
  parameter int CL    = 2,
  parameter int TWR   = 2,
  parameter int TRP   = 3,
  parameter int NB    = 4,
  parameter int ROW_W = 11,
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [1:0]            reqOp,
  input  logic [$clog2(NB)-1:0] reqBank,
  input  logic                  reqAllBanks,
  input  logic [ROW_W-1:0]      reqRow,
  input  logic [COL_W-1:0]      reqCol,
  input  logic [BL*DW-1:0]      reqWrData,
  output logic                  csN,
  output logic                  rasN,
  output logic                  casN,
  output logic                  weN,
  output logic [$clog2(NB)-1:0] sdBank,
  output logic [ROW_W-1:0]      sdAddr,
  output logic                  dqm,
  output logic [DW-1:0]         dqOut,
  output logic                  dqOe,
  input  logic [DW-1:0]         dqIn,
  output logic [DW-1:0]         rdData,
  output logic                  rdValid
);

  strobe_t    strobe;
  logic [3:0] cmd;

  assign {csN, rasN, casN, weN} = cmd;

  sdwiCtrl #(
    .BL(BL), .CL(CL), .TWR(TWR), .TRP(TRP), .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqBank(reqBank), .reqAllBanks(reqAllBanks),
    .reqRow(reqRow), .reqCol(reqCol), .cmd(cmd), .sdBank(sdBank),
    .sdAddr(sdAddr), .dqm(dqm), .dqOe(dqOe), .strobe(strobe)
  );

  sdwiData #(.DW(DW), .BL(BL)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .reqWrData(reqWrData),
    .dqIn(dqIn), .dqOut(dqOut), .rdData(rdData), .rdValid(rdValid)
  );

  initial begin
    assert (ROW_W >= 11 && COL_W <= 10 && TWR >= 1 && TRP >= 1 && CL >= 1 && BL >= 1)
      else $error("sdramWrIntrSeq: unsupported parameter set");
  end

endmodule

// File: tb/tb_sdramWrIntrSeq.sv
module tb_sdramWrIntrSeq;
  localparam int DW = 16, BL = 4, CL = 2, TWR = 2, TRP = 3, NB = 4, ROW_W = 11, COL_W = 8;
  localparam int BW = $clog2(NB);
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010;

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 1'b0, reqReady, reqAllBanks = 1'b0;
  logic [1:0] reqOp = '0;
  logic [BW-1:0] reqBank = '0, sdBank;
  logic [ROW_W-1:0] reqRow = '0, sdAddr;
  logic [COL_W-1:0] reqCol = '0;
  logic [BL*DW-1:0] reqWrData = '0;
  logic csN, rasN, casN, weN, dqm, dqOe, rdValid;
  logic [DW-1:0] dqOut, dqIn = '0, rdData;

  int cyc = 0, checks = 0, errors = 0;
  bit monOn = 0;

  // bench model of expected pin behaviour
  int wrStart = -100, wrEnd = -200, expCmdCyc = -1, maskS = -1, maskE = -2;
  int busyEnd = -1, rdStart = -1000;
  int lastPre [NB];
  logic [3:0] expCmd = NOP;
  logic [BW-1:0] expBank = '0;
  logic [ROW_W-1:0] expAddr = '0;
  logic [DW-1:0] wrD [BL];
  bit cutByWrite = 0;

  sdramWrIntrSeq dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqBank(reqBank), .reqAllBanks(reqAllBanks), .reqRow(reqRow), .reqCol(reqCol),
    .reqWrData(reqWrData), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .sdBank(sdBank), .sdAddr(sdAddr), .dqm(dqm), .dqOut(dqOut), .dqOe(dqOe),
    .dqIn(dqIn), .rdData(rdData), .rdValid(rdValid)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(int c);
    return DW'(c * 40503) ^ 16'h5A5A;
  endfunction

  function automatic int imax(int x, int y);
    return (x > y) ? x : y;
  endfunction

  always @(posedge clk) begin
    #1;
    dqIn = pat(cyc);
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // per-cycle monitor
  always @(negedge clk) begin
    if (monOn) begin
      automatic logic [3:0] c4 = {csN, rasN, casN, weN};
      automatic logic [3:0] e4 = (cyc == expCmdCyc) ? expCmd : NOP;
      automatic string tag = (e4 == WR) ? "R3" : (e4 == RD) ? "R5" :
                             (e4 == PRE) ? "R7" : (e4 == ACT) ? "R9" : "R2";
      automatic bit oeExp = (cyc >= wrStart) && (cyc <= wrEnd);
      automatic bit dqmExp = (cyc >= maskS) && (cyc <= maskE);
      automatic bit rvExp = (cyc >= rdStart + CL + 1) && (cyc <= rdStart + CL + BL);
      chk(c4 == e4, tag, "command pins", c4, e4);
      if (e4 != NOP && c4 == e4) begin
        chk(sdBank == expBank, tag, "bank", sdBank, expBank);
        chk(sdAddr == expAddr, tag, "address", sdAddr, expAddr);
      end
      chk(dqOe == oeExp, (cyc == rdStart) ? "R5" : "R3", "dqOe", dqOe, oeExp);
      if (oeExp && dqOe)
        chk(dqOut == wrD[cyc - wrStart], cutByWrite ? "R4" : "R3", "write beat",
            dqOut, wrD[cyc - wrStart]);
      chk(dqm == dqmExp, "R8", "dqm", dqm, dqmExp);
      chk(reqReady == (cyc > busyEnd), "R10", "reqReady", reqReady, (cyc > busyEnd));
      chk(rdValid == rvExp, "R6", "rdValid", rdValid, rvExp);
      if (rvExp && rdValid) chk(rdData == pat(cyc - 1), "R6", "rdData", rdData, pat(cyc - 1));
    end
  end

  task automatic send(logic [1:0] op, logic [BW-1:0] bank, bit all,
                      logic [ROW_W-1:0] row, logic [COL_W-1:0] col,
                      logic [BL*DW-1:0] data);
    int a, lb, origEnd, p;
    @(negedge clk);
    reqOp = op; reqBank = bank; reqAllBanks = all; reqRow = row;
    reqCol = col; reqWrData = data; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1;
    a = cyc;
    reqValid = 1'b0;
    origEnd = wrEnd;
    if (wrEnd > a - 1) wrEnd = a - 1;
    lb = (wrEnd >= wrStart) ? wrEnd : -1000;
    expBank = bank;
    case (op)
      2'd0: begin
        cutByWrite = (origEnd > a - 1) && (origEnd >= wrStart);
        wrStart = a; wrEnd = a + BL - 1;
        for (int i = 0; i < BL; i++) wrD[i] = data[i*DW +: DW];
        expCmdCyc = a; expCmd = WR; expAddr = ROW_W'(col);
      end
      2'd1: begin
        expCmdCyc = a; expCmd = RD; expAddr = ROW_W'(col);
        busyEnd = a + CL + BL - 1; rdStart = a;
      end
      2'd2: begin
        p = imax(a, lb + TWR);
        if ((origEnd > a - 1) && (origEnd >= wrStart)) begin maskS = a; maskE = p; end
        expCmdCyc = p; expCmd = PRE; expAddr = '0; expAddr[10] = all;
        busyEnd = p - 1;
        for (int b = 0; b < NB; b++) if (all || b == int'(bank)) lastPre[b] = p;
      end
      default: begin
        p = imax(a, lastPre[bank] + TRP);
        expCmdCyc = p; expCmd = ACT; expAddr = row; busyEnd = p - 1;
      end
    endcase
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) lastPre[b] = -1000;
    void'($urandom(32'd20251));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk({csN, rasN, casN, weN} == NOP, "R1", "pins after reset", {csN, rasN, casN, weN}, NOP);
    chk(dqOe == 1'b0, "R1", "dqOe after reset", dqOe, 0);
    chk(dqm == 1'b0, "R1", "dqm after reset", dqm, 0);
    chk(rdValid == 1'b0, "R1", "rdValid after reset", rdValid, 0);
    chk(reqReady == 1'b1, "R1", "reqReady after reset", reqReady, 1);
    monOn = 1;
    // full burst, R3
    send(2'd0, 2'd1, 0, '0, 8'h05, 64'h4444_3333_2222_1111);
    idle(6);
    // write cut by write on the next clock, R4
    send(2'd0, 2'd2, 0, '0, 8'h10, 64'hA4A4_A3A3_A2A2_A1A1);
    send(2'd0, 2'd2, 0, '0, 8'h20, 64'hB4B4_B3B3_B2B2_B1B1);
    idle(6);
    // write cut by read, R5 and R6
    send(2'd0, 2'd0, 0, '0, 8'h30, 64'hC4C4_C3C3_C2C2_C1C1);
    send(2'd1, 2'd0, 0, '0, 8'h40, '0);
    idle(8);
    // precharge mid-burst, R7 and R8 with mask
    send(2'd0, 2'd3, 0, '0, 8'h50, 64'hD4D4_D3D3_D2D2_D1D1);
    idle(1);
    send(2'd2, 2'd3, 0, '0, '0, '0);
    idle(4);
    // precharge after a finished burst, mask low
    send(2'd0, 2'd1, 0, '0, 8'h60, 64'hE4E4_E3E3_E2E2_E1E1);
    idle(8);
    send(2'd2, 2'd1, 0, '0, '0, '0);
    // precharge all, then activate that must wait, R9
    send(2'd2, 2'd0, 1, '0, '0, '0);
    send(2'd3, 2'd2, 0, 11'h2A5, '0, '0);
    idle(4);
    // seeded random mix
    for (int n = 0; n < 600; n++) begin
      automatic int sel = $urandom_range(0, 9);
      automatic logic [1:0] op = (sel < 5) ? 2'd0 : (sel < 7) ? 2'd1 : (sel < 9) ? 2'd2 : 2'd3;
      idle($urandom_range(0, 3));
      send(op, BW'($urandom_range(0, NB - 1)), ($urandom_range(0, 3) == 0),
           ROW_W'($urandom), COL_W'($urandom), {$urandom, $urandom});
    end
    idle(12);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule